// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of an 8-bit successive-approximation converter. Software controls it through a single control write that carries an enable bit, a start/busy bit and a 2-bit conversion-clock select. A separate write path loads the result register directly. The block derives a per-bit conversion clock from the system clock, or takes half-period ticks from a separate RC oscillator. It drives trial codes to an external DAC and reads a comparator that reports whether the analog input is at or above the trial code. It then resolves the bits from most significant to least significant.

A finished conversion loads the result, clears the busy bit and raises an interrupt flag. A conversion can be cut short in four ways: a software abort, disabling the converter, entering sleep while a system-clock source is selected, or reset. None of these touches the result. A software abort is followed by a fixed recovery wait before acquisition resumes.

When the RC source is selected, a start first waits a fixed number of system clocks. The conversion then keeps running through sleep, and on completion it either requests wake-up or powers the converter down. A trigger from a compare unit in the matching mode can start a conversion, and it always pulses a timer-restart output, whether or not the converter is enabled.

Top module: `sar_seq`

## Requirements
- R1: During and right after reset, the converter is disabled and idle: en_stat, busy, irq, acq, active, wake and tmr_rst all read 0.
- R2: With select code 00, 01 or 10, the half conversion-clock period is 1, 4 or 16 system clocks. A started conversion keeps busy high for exactly 19 half periods (9.5 conversion-clock periods), counted from the edge that takes the start.
- R3: On a normal finish, busy clears, result loads the resolved code and irq sets in the same edge. With a comparator that is high when the input is at or above the trial code, result equals the input value.
- R4: A start is ignored when the converter is disabled, including a start written in the same write that turns the enable bit from 0 to 1.
- R5: A control write with enable 1 and go 0 during a conversion aborts it. The result is unchanged and irq is not set. A recovery wait of 4 half periods follows, during which acq is low and start writes are ignored. acq returns high at the end of the wait.
- R6: With select code 11, a start waits PRE_CLKS system clocks and then advances one half period per rc_tick pulse. The conversion ends after 19 such pulses, and cycles with rc_tick low make no progress.
- R7: In sleep with the RC source, a conversion runs to completion. If irq_en is high, wake pulses for one cycle when the result loads. If irq_en is low, active drops to 0 while en_stat stays 1, until sleep falls.
- R8: While sleep is high with a system-clock source, any conversion stops without loading the result or setting irq. active reads 0 and en_stat stays 1. active returns one edge after sleep falls.
- R9: A trig pulse with trig_mode equal to 1011 pulses tmr_rst on the next cycle whether or not the converter is enabled. It starts a conversion only when the converter is enabled and idle. Any other mode value does neither.
- R10: A result write loads res_wdata into result on the next edge.
- R11: Writing the enable bit to 0 during a conversion stops it at once, without loading the result or setting irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable bit value written |
| ctl_go | input | 1 | Start/busy bit value written |
| ctl_sel | input | 2 | Conversion clock select written (00, 01, 10 divided, 11 RC) |
| res_wr | input | 1 | Result write strobe |
| res_wdata | input | 8 | Result write value |
| irq_en | input | 1 | Interrupt enable, gates the wake request |
| irq_clr | input | 1 | Clears the interrupt flag |
| sleep | input | 1 | Device is in sleep |
| rc_tick | input | 1 | Half-period tick of the RC conversion clock |
| trig | input | 1 | Compare-unit event pulse |
| trig_mode | input | 4 | Compare-unit mode field |
| cmp_in | input | 1 | Comparator: input at or above the trial code |
| dac_code | output | 8 | Trial code to the DAC |
| result | output | 8 | Result register |
| en_stat | output | 1 | Enable bit readback |
| busy | output | 1 | Start/busy bit readback |
| active | output | 1 | Converter powered |
| acq | output | 1 | Acquisition running, ready for a start |
| irq | output | 1 | Conversion-done interrupt flag |
| wake | output | 1 | One-cycle wake request |
| tmr_rst | output | 1 | Timer restart pulse |

## Verification
The bench counts the exact cycle in which busy falls for every clock select. A divider that is off by one period, or that is not restarted at the start edge, therefore misses the check by a whole half period, and a final half period that is not covered ends the conversion too early. An abort late in a conversion must leave the old result and must hold acq low for the full 4 half periods, so a design that loads partial codes, or skips the recovery wait, shows the wrong value or an early acq. The bench also covers a start written together with the enable bit, triggers while disabled, and both sleep cases. A design that starts on the enabling write, gates tmr_rst with the enable bit, or powers down on an RC conversion in sleep is caught by busy, tmr_rst, active or wake.

// File: rtl/sar_pkg.sv
package sar_pkg;
    // Sequencer phases: idle/acquiring, RC pre-wait, converting, abort recovery
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_CONV = 2'd2,
        ST_REC  = 2'd3
    } sar_state_e;

    localparam logic [1:0] SEL_RC        = 2'b11;
    localparam logic [3:0] TRIG_MODE_ADC = 4'b1011;
    localparam int         REC_HALVES    = 4;
endpackage

// File: rtl/sar_tick_gen.sv
// Half-period tick generator for the conversion clock.
// Produces one-cycle htick pulses every DIVx/2 system clocks for select
// codes 0..2, or passes rc_tick through for the RC source. Assumes every
// DIVx is even and at least 2. The count restarts on clr and while idle,
// so the first tick of a phase comes exactly one half period after clr.
module sar_tick_gen #(
    parameter int DIV0 = 2,
    parameter int DIV1 = 8,
    parameter int DIV2 = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       run,
    input  logic [1:0] sel,
    input  logic       rc_tick,
    output logic       htick
);
    import sar_pkg::*;

    localparam int HP0   = DIV0 / 2;
    localparam int HP1   = DIV1 / 2;
    localparam int HP2   = DIV2 / 2;
    localparam int HPMAX = (HP0 > HP1) ? ((HP0 > HP2) ? HP0 : HP2)
                                       : ((HP1 > HP2) ? HP1 : HP2);
    localparam int CW    = $clog2(HPMAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Pick the terminal count for the selected divider
    always_comb begin
        case (sel)
            2'b00:   lim = CW'(HP0 - 1);
            2'b01:   lim = CW'(HP1 - 1);
            default: lim = CW'(HP2 - 1);
        endcase
    end

    // Free-running half-period counter, restarted at each phase change
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run || cnt >= lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Tick output: RC pulses or divider terminal count
    always_comb begin
        if (sel == SEL_RC) begin
            htick = run && !clr && rc_tick;
        end else begin
            htick = run && !clr && (cnt == lim);
        end
    end
endmodule

// File: rtl/sar_approx.sv
// Successive-approximation register.
// init loads the MSB trial code. Each step keeps or drops the current
// trial bit using cmp (high means the input is at or above the trial code)
// and raises the next lower bit. After W steps, code holds the result.
module sar_approx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         step,
    input  logic         cmp,
    output logic [W-1:0] code
);
    logic [W-1:0] mask;

    // Trial code and bit pointer update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
            mask <= '0;
        end else if (init) begin
            code <= {1'b1, {(W-1){1'b0}}};
            mask <= {1'b1, {(W-1){1'b0}}};
        end else if (step) begin
            code <= (cmp ? code : (code & ~mask)) | (mask >> 1);
            mask <= mask >> 1;
        end
    end
endmodule

// File: rtl/sar_ctrl.sv
// Conversion sequencer control.
// Holds the enable, clock-select and interrupt state and runs the phase
// machine. Phase order is idle, then an optional RC pre-wait, then the
// conversion. An abort path leads through a recovery wait back to idle.
// Kill priority, highest first: disable write, sleep with a system-clock
// source, software abort. A conversion lasts 2*W+3 half periods. Bits are
// sampled on the even counts up to 2*W, and the last half period covers
// the result load.
module sar_ctrl #(
    parameter int W        = 8,
    parameter int PRE_CLKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic       ctl_en,
    input  logic       ctl_go,
    input  logic [1:0] ctl_sel,
    input  logic       irq_en,
    input  logic       irq_clr,
    input  logic       sleep,
    input  logic       trig,
    input  logic [3:0] trig_mode,
    input  logic       htick,
    output logic [1:0] sel_q,
    output logic       run,
    output logic       div_clr,
    output logic       conv_init,
    output logic       sar_step,
    output logic       load_res,
    output logic       busy,
    output logic       en_stat,
    output logic       active,
    output logic       acq,
    output logic       irq,
    output logic       wake,
    output logic       tmr_rst
);
    import sar_pkg::*;

    localparam int TOTAL  = 2 * W + 3;
    localparam int SLAST  = 2 * W;
    localparam int HW     = $clog2(2 * W + 4);
    localparam int PW     = (PRE_CLKS > 1) ? $clog2(PRE_CLKS + 1) : 1;

    sar_state_e    state, state_n;
    logic [HW-1:0] hcnt, hcnt_n, h_next;
    logic [PW-1:0] pre_cnt, pre_n;
    logic          en_q, pdn_q, irq_q, wake_q, tmr_q;
    logic [1:0]    sel_n;
    logic          rc_q, rc_n, wr_dis, trig_hit, start, sw_abort, slp_kill;

    // Decode write, trigger and kill conditions
    always_comb begin
        sel_n    = ctl_wr ? ctl_sel : sel_q;
        rc_q     = (sel_q == SEL_RC);
        rc_n     = (sel_n == SEL_RC);
        wr_dis   = ctl_wr && !ctl_en;
        trig_hit = trig && (trig_mode == TRIG_MODE_ADC);
        start    = en_q && !wr_dis && !pdn_q && !(sleep && !rc_n) &&
                   (state == ST_IDLE) && ((ctl_wr && ctl_go) || trig_hit);
        sw_abort = ctl_wr && ctl_en && !ctl_go &&
                   ((state == ST_PRE) || (state == ST_CONV));
        slp_kill = sleep && !rc_q && (state != ST_IDLE);
        h_next   = hcnt + 1'b1;
    end

    // Phase machine next state and datapath strobes
    always_comb begin
        state_n   = state;
        hcnt_n    = hcnt;
        pre_n     = pre_cnt;
        div_clr   = 1'b0;
        conv_init = 1'b0;
        sar_step  = 1'b0;
        load_res  = 1'b0;
        if (wr_dis || slp_kill) begin
            state_n = ST_IDLE;
        end else if (sw_abort) begin
            state_n = ST_REC;
            hcnt_n  = '0;
            div_clr = 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (rc_n) begin
                            state_n = ST_PRE;
                            pre_n   = '0;
                        end else begin
                            state_n   = ST_CONV;
                            hcnt_n    = '0;
                            div_clr   = 1'b1;
                            conv_init = 1'b1;
                        end
                    end
                end
                ST_PRE: begin
                    if (pre_cnt == PW'(PRE_CLKS - 1)) begin
                        state_n   = ST_CONV;
                        hcnt_n    = '0;
                        div_clr   = 1'b1;
                        conv_init = 1'b1;
                    end else begin
                        pre_n = pre_cnt + 1'b1;
                    end
                end
                ST_CONV: begin
                    if (htick) begin
                        hcnt_n = h_next;
                        if (!h_next[0] && (h_next <= HW'(SLAST))) begin
                            sar_step = 1'b1;
                        end
                        if (h_next == HW'(TOTAL)) begin
                            state_n  = ST_IDLE;
                            load_res = 1'b1;
                        end
                    end
                end
                default: begin
                    if (htick) begin
                        hcnt_n = h_next;
                        if (h_next == HW'(REC_HALVES)) begin
                            state_n = ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // Phase, counters and software-visible control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            hcnt    <= '0;
            pre_cnt <= '0;
            en_q    <= 1'b0;
            sel_q   <= 2'b00;
        end else begin
            state   <= state_n;
            hcnt    <= hcnt_n;
            pre_cnt <= pre_n;
            en_q    <= ctl_wr ? ctl_en : en_q;
            sel_q   <= sel_n;
        end
    end

    // Power-down, interrupt, wake and timer-restart flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pdn_q  <= 1'b0;
            irq_q  <= 1'b0;
            wake_q <= 1'b0;
            tmr_q  <= 1'b0;
        end else begin
            if (sleep && !rc_q) begin
                pdn_q <= 1'b1;
            end else if (!sleep) begin
                pdn_q <= 1'b0;
            end else if (load_res && !irq_en) begin
                pdn_q <= 1'b1;
            end
            if (load_res) begin
                irq_q <= 1'b1;
            end else if (irq_clr) begin
                irq_q <= 1'b0;
            end
            wake_q <= load_res && sleep && irq_en;
            tmr_q  <= trig_hit;
        end
    end

    assign run     = (state != ST_IDLE);
    assign busy    = (state == ST_PRE) || (state == ST_CONV);
    assign en_stat = en_q;
    assign active  = en_q && !pdn_q;
    assign acq     = active && (state == ST_IDLE);
    assign irq     = irq_q;
    assign wake    = wake_q;
    assign tmr_rst = tmr_q;
endmodule

// File: rtl/sar_seq.sv
// Successive-approximation conversion sequencer, top level.
// Ties the control machine, the conversion clock divider and the
// approximation register together and holds the software result register.
// A completed conversion has priority over a software result write in the
// same cycle.
module sar_seq #(
    parameter int W        = 8,
    parameter int DIV0     = 2,
    parameter int DIV1     = 8,
    parameter int DIV2     = 32,
    parameter int PRE_CLKS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctl_wr,
    input  logic         ctl_en,
    input  logic         ctl_go,
    input  logic [1:0]   ctl_sel,
    input  logic         res_wr,
    input  logic [W-1:0] res_wdata,
    input  logic         irq_en,
    input  logic         irq_clr,
    input  logic         sleep,
    input  logic         rc_tick,
    input  logic         trig,
    input  logic [3:0]   trig_mode,
    input  logic         cmp_in,
    output logic [W-1:0] dac_code,
    output logic [W-1:0] result,
    output logic         en_stat,
    output logic         busy,
    output logic         active,
    output logic         acq,
    output logic         irq,
    output logic         wake,
    output logic         tmr_rst
);
    logic [1:0] sel_q;
    logic       run, div_clr, conv_init, sar_step, load_res, htick;

    sar_ctrl #(.W(W), .PRE_CLKS(PRE_CLKS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_go(ctl_go), .ctl_sel(ctl_sel),
        .irq_en(irq_en), .irq_clr(irq_clr), .sleep(sleep),
        .trig(trig), .trig_mode(trig_mode), .htick(htick),
        .sel_q(sel_q), .run(run), .div_clr(div_clr), .conv_init(conv_init),
        .sar_step(sar_step), .load_res(load_res), .busy(busy),
        .en_stat(en_stat), .active(active), .acq(acq), .irq(irq),
        .wake(wake), .tmr_rst(tmr_rst)
    );

    sar_tick_gen #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(div_clr), .run(run),
        .sel(sel_q), .rc_tick(rc_tick), .htick(htick)
    );

    sar_approx #(.W(W)) u_sar (
        .clk(clk), .rst_n(rst_n), .init(conv_init), .step(sar_step),
        .cmp(cmp_in), .code(dac_code)
    );

    // Result register: conversion load wins over a software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (load_res) begin
            result <= dac_code;
        end else if (res_wr) begin
            result <= res_wdata;
        end
    end
endmodule

// File: rtl/sar_seq_chk.sv
// Property checker for the conversion sequencer, bound to every sar_seq.
module sar_seq_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ctl_wr,
    input logic         ctl_en,
    input logic         ctl_go,
    input logic         res_wr,
    input logic         irq_en,
    input logic         sleep,
    input logic         trig,
    input logic [3:0]   trig_mode,
    input logic [W-1:0] result,
    input logic         en_stat,
    input logic         busy,
    input logic         active,
    input logic         irq,
    input logic         wake,
    input logic         tmr_rst
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!busy && !en_stat && !irq && !wake)); // R1

    AST_DONE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(ctl_wr) && !$past(sleep)) |-> irq); // R3

    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_stat && !busy) |=> !busy); // R4

    AST_ABORT_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_wr && ctl_en && !ctl_go && !res_wr) |=> $stable(result)); // R5

    AST_WAKE_NEEDS_IRQEN: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> ($past(irq_en) && $past(sleep))); // R7

    AST_PDN_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(active) && !$past(ctl_wr)) |-> en_stat); // R8

    AST_TRIG_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && trig_mode == 4'b1011) |=> tmr_rst); // R9

    AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_en) |=> !busy); // R11
endmodule

bind sar_seq sar_seq_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
    .ctl_go(ctl_go), .res_wr(res_wr), .irq_en(irq_en), .sleep(sleep),
    .trig(trig), .trig_mode(trig_mode), .result(result), .en_stat(en_stat),
    .busy(busy), .active(active), .irq(irq), .wake(wake), .tmr_rst(tmr_rst)
);

// File: tb/sim_sar_seq.sv
module sim_sar_seq;
    localparam int PRE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0, ctl_en = 1'b0, ctl_go = 1'b0;
    logic [1:0] ctl_sel = 2'b00;
    logic       res_wr = 1'b0;
    logic [7:0] res_wdata = 8'h00;
    logic       irq_en = 1'b0, irq_clr = 1'b0, sleep = 1'b0, rc_tick = 1'b0;
    logic       trig = 1'b0;
    logic [3:0] trig_mode = 4'b0000;
    logic [7:0] vin = 8'h00;
    logic       cmp_in;
    logic [7:0] dac_code, result;
    logic       en_stat, busy, active, acq, irq, wake, tmr_rst;

    int checks = 0;
    int errors = 0;
    int wd = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    assign cmp_in = (vin >= dac_code);

    sar_seq #(.PRE_CLKS(PRE)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
        .ctl_go(ctl_go), .ctl_sel(ctl_sel), .res_wr(res_wr),
        .res_wdata(res_wdata), .irq_en(irq_en), .irq_clr(irq_clr),
        .sleep(sleep), .rc_tick(rc_tick), .trig(trig), .trig_mode(trig_mode),
        .cmp_in(cmp_in), .dac_code(dac_code), .result(result),
        .en_stat(en_stat), .busy(busy), .active(active), .acq(acq),
        .irq(irq), .wake(wake), .tmr_rst(tmr_rst)
    );

    function automatic int half_of(input int sel);
        return (sel == 0) ? 1 : ((sel == 1) ? 4 : 16);
    endfunction

    function automatic int conv_len(input int sel);
        return 19 * half_of(sel);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input bit en, input bit go, input int sel);
        ctl_wr = 1'b1; ctl_en = en; ctl_go = go; ctl_sel = 2'(sel);
        @(negedge clk);
        ctl_wr = 1'b0; ctl_go = 1'b0;
    endtask

    task automatic clr_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic run_conv(input int sel, input logic [7:0] v);
        vin = v;
        clr_irq();
        wr_ctl(1'b1, 1'b1, sel);
        chk("R2 busy after start", int'(busy), 1);
        cyc(conv_len(sel) - 1);
        chk("R2 busy before last half period", int'(busy), 1);
        cyc(1);
        chk("R2 busy cleared at 19 half periods", int'(busy), 0);
        chk("R3 result equals input", int'(result), int'(v));
        chk("R3 irq set on finish", int'(irq), 1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd == 100000 && !finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", wd);
            summary();
        end
    end

    initial begin
        logic [7:0] prev;
        void'($urandom(32'd20240611));
        cyc(3);
        // R1 reset state
        chk("R1 en_stat", int'(en_stat), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 acq", int'(acq), 0);
        chk("R1 active", int'(active), 0);
        chk("R1 wake", int'(wake), 0);
        chk("R1 tmr_rst", int'(tmr_rst), 0);
        rst_n = 1'b1;
        cyc(1);

        // R10 software result write
        res_wr = 1'b1; res_wdata = 8'h5A;
        cyc(1);
        res_wr = 1'b0;
        chk("R10 result write", int'(result), 8'h5A);

        // R9 trigger while disabled: timer pulse only
        trig = 1'b1; trig_mode = 4'b1011;
        cyc(1);
        trig = 1'b0;
        chk("R9 tmr_rst while disabled", int'(tmr_rst), 1);
        chk("R9 no start while disabled", int'(busy), 0);
        cyc(1);
        chk("R9 tmr_rst single pulse", int'(tmr_rst), 0);

        // R4 start in the enabling write is ignored
        wr_ctl(1'b1, 1'b1, 0);
        chk("R4 en_stat set", int'(en_stat), 1);
        chk("R4 go ignored on enabling write", int'(busy), 0);
        chk("R4 acq after enable", int'(acq), 1);

        // R2/R3 directed extremes and slowest divider
        run_conv(0, 8'h00);
        run_conv(0, 8'hFF);
        run_conv(2, 8'h80);
        run_conv(1, 8'h7F);

        // R2/R3 random patterns
        for (int i = 0; i < 20; i++) begin
            run_conv(int'($urandom % 3), 8'($urandom));
        end

        // R5 abort late in a conversion, recovery wait, ignored start
        clr_irq();
        prev = result;
        vin = ~prev;
        wr_ctl(1'b1, 1'b1, 1);
        cyc(60);
        wr_ctl(1'b1, 1'b0, 1);
        chk("R5 busy cleared by abort", int'(busy), 0);
        chk("R5 result kept on abort", int'(result), int'(prev));
        chk("R5 acq low in recovery", int'(acq), 0);
        wr_ctl(1'b1, 1'b1, 1);
        chk("R5 start ignored in recovery", int'(busy), 0);
        cyc(14);
        chk("R5 acq low at end of wait", int'(acq), 0);
        cyc(1);
        chk("R5 acq back after 4 half periods", int'(acq), 1);
        chk("R5 no irq on abort", int'(irq), 0);
        chk("R5 result still kept", int'(result), int'(prev));
        run_conv(1, 8'h3C);

        // R11 disable during a conversion
        clr_irq();
        prev = result;
        vin = 8'hC3;
        wr_ctl(1'b1, 1'b1, 1);
        cyc(20);
        wr_ctl(1'b0, 1'b0, 1);
        chk("R11 busy cleared by disable", int'(busy), 0);
        chk("R11 en_stat cleared", int'(en_stat), 0);
        cyc(80);
        chk("R11 result kept", int'(result), int'(prev));
        chk("R11 no irq", int'(irq), 0);
        wr_ctl(1'b1, 1'b0, 1);

        // R9 wrong mode ignored, right mode starts with enable set
        trig = 1'b1; trig_mode = 4'b1010;
        cyc(1);
        trig = 1'b0;
        chk("R9 wrong mode no start", int'(busy), 0);
        chk("R9 wrong mode no timer pulse", int'(tmr_rst), 0);
        vin = 8'h99;
        trig = 1'b1; trig_mode = 4'b1011;
        cyc(1);
        trig = 1'b0;
        chk("R9 trigger starts conversion", int'(busy), 1);
        chk("R9 tmr_rst with enable", int'(tmr_rst), 1);
        cyc(75);
        chk("R9 busy before end", int'(busy), 1);
        cyc(1);
        chk("R9 triggered result", int'(result), 8'h99);

        // R6 RC source: pre-wait then one half period per rc_tick
        clr_irq();
        vin = 8'h4D;
        rc_tick = 1'b1;
        wr_ctl(1'b1, 1'b1, 3);
        chk("R6 busy in pre-wait", int'(busy), 1);
        cyc(PRE + 5);
        rc_tick = 1'b0;
        cyc(10);
        rc_tick = 1'b1;
        chk("R6 stalled without ticks", int'(busy), 1);
        cyc(13);
        chk("R6 busy before last tick", int'(busy), 1);
        cyc(1);
        chk("R6 done after pre-wait and 19 ticks", int'(busy), 0);
        chk("R6 result", int'(result), 8'h4D);

        // R7 RC conversion in sleep with interrupt enabled
        clr_irq();
        irq_en = 1'b1;
        vin = 8'hE1;
        wr_ctl(1'b1, 1'b1, 3);
        sleep = 1'b1;
        cyc(PRE + 18);
        chk("R7 still converting in sleep", int'(busy), 1);
        chk("R7 no early wake", int'(wake), 0);
        cyc(1);
        chk("R7 done in sleep", int'(busy), 0);
        chk("R7 wake pulse", int'(wake), 1);
        chk("R7 result in sleep", int'(result), 8'hE1);
        chk("R7 stays powered", int'(active), 1);
        cyc(1);
        chk("R7 wake one cycle", int'(wake), 0);
        sleep = 1'b0;
        cyc(1);

        // R7 RC conversion in sleep with interrupt disabled
        clr_irq();
        irq_en = 1'b0;
        vin = 8'h12;
        wr_ctl(1'b1, 1'b1, 3);
        sleep = 1'b1;
        cyc(PRE + 19);
        chk("R7 done without irq_en", int'(busy), 0);
        chk("R7 no wake without irq_en", int'(wake), 0);
        chk("R7 powered down", int'(active), 0);
        chk("R7 enable kept", int'(en_stat), 1);
        chk("R7 irq flag still set", int'(irq), 1);
        sleep = 1'b0;
        cyc(1);
        chk("R7 powered after sleep ends", int'(active), 1);

        // R8 sleep with a divided clock aborts
        clr_irq();
        prev = result;
        vin = 8'hAA;
        wr_ctl(1'b1, 1'b1, 1);
        cyc(10);
        sleep = 1'b1;
        cyc(1);
        chk("R8 busy cleared by sleep", int'(busy), 0);
        chk("R8 powered down", int'(active), 0);
        chk("R8 enable kept", int'(en_stat), 1);
        cyc(100);
        chk("R8 result kept", int'(result), int'(prev));
        chk("R8 no irq", int'(irq), 0);
        sleep = 1'b0;
        cyc(1);
        chk("R8 powered after sleep ends", int'(active), 1);

        summary();
    end
endmodule